// File: doc/BRIEF.md
# Strap-Configured Parallel Register Slave

This block answers a host processor's asynchronous parallel bus. The host drives an active-low chip select, a read/write level, a 4-bit word address, a 32-bit data word and one parity bit. The block replies with a transfer-acknowledge and, on reads, with a data word and a parity bit. Behind the bus sits a file of sixteen 32-bit registers.

Five pins of a general-purpose I/O group double as configuration straps. The block captures them while synchronous reset is held, and the captured values set five things: the active level of the acknowledge, the sense of the read/write line, whether write parity is checked, odd or even parity, and whether the acknowledge is held or pulsed. After reset these pins are ordinary inputs, and moving them has no effect on the captured configuration.

Chip select and read/write pass through a synchronizer first. A write whose parity is wrong, while checking is enabled, is discarded and latches an error flag. The read data and the acknowledge model their tristate pads with separate output-enable signals.

Top module: `pbus_strap_slave`

## Requirements
- R1: On every rising edge while `rst` is high, straps are captured from `gpio_in`: bit 0 = acknowledge active high, bit 1 = read/write inverted, bit 2 = ignore parity, bit 3 = even parity, bit 4 = hold acknowledge. After reset the captured values stay fixed whatever `gpio_in` does. `gpio_oe` is all zeros, so every pin is an input, and `gpio_rd` shows `gpio_in` one clock later.
- R2: The acknowledge is active at `ack`=1 when strap bit 0 is 1, and active at `ack`=0 when strap bit 0 is 0. Whenever `ack_oe` is high and the acknowledge is not active, `ack` sits at the inactive level.
- R3: With strap bit 1 at 0, `rw`=1 means read and `rw`=0 means write. With strap bit 1 at 1, the meanings swap.
- R4: With strap bit 3 at 1, the count of ones in `rdata` plus `rpar` is even. With it at 0, that count is odd. Write parity uses the same rule on `wdata` and `wpar`.
- R5: With strap bit 2 at 0, a write whose parity breaks the R4 rule leaves the register file unchanged and sets `par_err`. `par_err` stays set until the next reset.
- R6: With strap bit 2 at 1, every write is stored whatever its parity, and `par_err` stays 0.
- R7: With the default two synchronizer stages, the acknowledge goes active after the third rising edge that follows `cs_n` going low.
- R8: With strap bit 4 at 1, the acknowledge stays active until chip select is released. It becomes undriven (`ack_oe`=0) after the third rising edge that follows `cs_n` going high, and it is never driven at the inactive level.
- R9: With strap bit 4 at 0, the acknowledge is active for exactly one cycle. It is then driven at the inactive level for one cycle and then left undriven, even while chip select is still held.
- R10: `rd_oe` is high only while the acknowledge is active on a read, and it is never high on a write.
- R11: The sixteen 32-bit registers reset to zero. A read returns the last word stored at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps are captured while it is high |
| gpio_in | input | 8 | Strap / general-purpose pin input levels |
| gpio_rd | output | 8 | Registered pin levels for general-purpose use |
| gpio_oe | output | 8 | Pin output enables (all zero: inputs) |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rw | input | 1 | Read/write level, sense set by strap |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data from host |
| wpar | input | 1 | Write data parity bit |
| rdata | output | 32 | Read data to host |
| rpar | output | 1 | Read data parity bit |
| rd_oe | output | 1 | Output enable for rdata and rpar |
| ack | output | 1 | Transfer acknowledge level |
| ack_oe | output | 1 | Output enable for ack |
| par_err | output | 1 | Sticky write parity error |

## Verification
The bound checker watches, on every cycle, the relations that never depend on the transfer's history. Read data is enabled only under an active acknowledge. In hold mode the acknowledge is never driven inactive. A pulsed acknowledge lasts one cycle, then one inactive driven cycle, then release. The error flag is sticky, and the straps stay frozen after reset. The bench walks all 32 strap combinations with a fixed-seed random mix of reads, writes and bad-parity writes. Only these scenarios can show the three-cycle latency, the read/write decoding, parity values, dropped writes, read-back contents and immunity to pin changes after reset.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   // Latched configuration; bit order matches gpio_in[4:0]
   typedef struct packed {
      logic hold;      // bit 4
      logic par_even;  // bit 3
      logic par_ign;   // bit 2
      logic rw_inv;    // bit 1
      logic ack_high;  // bit 0
   } strap_t;

   localparam int STRAP_W = $bits(strap_t);

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_ACK  = 2'd1,
      XS_NEG  = 2'd2,
      XS_WAIT = 2'd3
   } xfer_st_e;

endpackage

// File: rtl/pbus_strap_gpio.sv
module pbus_strap_gpio
   import pbus_pkg::*;
#(
   parameter int GPIO_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [GPIO_W-1:0] pins_i,
   output strap_t            straps_o,
   output logic [GPIO_W-1:0] gpio_rd_o,
   output logic [GPIO_W-1:0] gpio_oe_o
);

   strap_t            straps_q;
   logic [GPIO_W-1:0] pins_q;

   // Capture continuously during reset; the last reset edge wins
   always_ff @(posedge clk) begin
      if (rst) straps_q <= strap_t'(pins_i[STRAP_W-1:0]);
      pins_q <= pins_i;
   end

   assign straps_o  = straps_q;
   assign gpio_rd_o = pins_q;
   assign gpio_oe_o = '0;

endmodule

// File: rtl/pbus_sync.sv
module pbus_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pbus_parity.sv
module pbus_parity #(
   parameter int W = 32
) (
   input  logic [W-1:0] data_i,
   input  logic         even_i,
   output logic         par_o
);

   // Bit that makes the total ones count even (even_i=1) or odd (even_i=0)
   assign par_o = even_i ? (^data_i) : ~(^data_i);

endmodule

// File: rtl/pbus_xfer_fsm.sv
module pbus_xfer_fsm
   import pbus_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic hold_i,
   input  logic rw_inv_i,
   input  logic cs_act_i,
   input  logic rw_lvl_i,
   output logic start_o,
   output logic start_rd_o,
   output logic ack_act_o,
   output logic ack_drv_o,
   output logic rd_drv_o
);

   xfer_st_e st_q;
   logic     rd_q;

   assign start_o    = (st_q == XS_IDLE) && cs_act_i;
   assign start_rd_o = rw_lvl_i ^ rw_inv_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= XS_IDLE;
         rd_q <= 1'b0;
      end else begin
         unique case (st_q)
            XS_IDLE: if (cs_act_i) begin
               st_q <= XS_ACK;
               rd_q <= start_rd_o;
            end
            XS_ACK:  if (!hold_i)        st_q <= XS_NEG;
                     else if (!cs_act_i) st_q <= XS_IDLE;
            XS_NEG:  st_q <= XS_WAIT;
            XS_WAIT: if (!cs_act_i)      st_q <= XS_IDLE;
            default: st_q <= XS_IDLE;
         endcase
      end
   end

   assign ack_act_o = (st_q == XS_ACK);
   assign ack_drv_o = (st_q == XS_ACK) || (st_q == XS_NEG);
   assign rd_drv_o  = (st_q == XS_ACK) && rd_q;

endmodule

// File: rtl/pbus_strap_slave.sv
module pbus_strap_slave
   import pbus_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int GPIO_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [GPIO_W-1:0] gpio_in,
   output logic [GPIO_W-1:0] gpio_rd,
   output logic [GPIO_W-1:0] gpio_oe,
   input  logic              cs_n,
   input  logic              rw,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wpar,
   output logic [DATA_W-1:0] rdata,
   output logic              rpar,
   output logic              rd_oe,
   output logic              ack,
   output logic              ack_oe,
   output logic              par_err
);

   localparam int DEPTH = 1 << ADDR_W;

   if (GPIO_W < STRAP_W) begin : g_chk_gpio
      $error("GPIO_W must cover all strap bits");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_chk_dims
      $error("DATA_W and ADDR_W must be positive");
   end

   strap_t            straps_q;
   logic [1:0]        bus_s;
   logic              cs_act_s;
   logic              start, start_rd, ack_act, ack_drv, rd_drv;
   logic              wpar_exp;
   logic              wpar_ok;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] mem [DEPTH];
   logic              err_q;

   pbus_strap_gpio #(.GPIO_W(GPIO_W)) strap_i (
      .clk(clk), .rst(rst), .pins_i(gpio_in),
      .straps_o(straps_q), .gpio_rd_o(gpio_rd), .gpio_oe_o(gpio_oe)
   );

   pbus_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b01)) sync_i (
      .clk(clk), .rst(rst), .d_i({rw, cs_n}), .q_o(bus_s)
   );
   assign cs_act_s = ~bus_s[0];

   pbus_xfer_fsm fsm_i (
      .clk(clk), .rst(rst),
      .hold_i(straps_q.hold), .rw_inv_i(straps_q.rw_inv),
      .cs_act_i(cs_act_s), .rw_lvl_i(bus_s[1]),
      .start_o(start), .start_rd_o(start_rd),
      .ack_act_o(ack_act), .ack_drv_o(ack_drv), .rd_drv_o(rd_drv)
   );

   pbus_parity #(.W(DATA_W)) wpar_i (
      .data_i(wdata), .even_i(straps_q.par_even), .par_o(wpar_exp)
   );
   pbus_parity #(.W(DATA_W)) rpar_i (
      .data_i(rdata), .even_i(straps_q.par_even), .par_o(rpar)
   );

   assign wpar_ok = straps_q.par_ign || (wpar == wpar_exp);

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         err_q  <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (start) begin
         addr_q <= addr;
         if (!start_rd) begin
            if (wpar_ok) mem[addr] <= wdata;
            else         err_q     <= 1'b1;
         end
      end
   end

   assign rdata   = mem[addr_q];
   assign rd_oe   = rd_drv;
   assign ack     = ack_act ? straps_q.ack_high : ~straps_q.ack_high;
   assign ack_oe  = ack_drv;
   assign par_err = err_q;

endmodule

// File: rtl/pbus_strap_slave_chk.sv
module pbus_strap_slave_chk
   import pbus_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  strap_t straps,
   input  logic   ack,
   input  logic   ack_oe,
   input  logic   rd_oe,
   input  logic   par_err
);

   logic ack_on;
   assign ack_on = ack_oe && (ack == straps.ack_high);

   // R10
   rd_oe_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
      rd_oe |-> ack_on);

   // R9
   pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      (ack_on && !straps.hold) |=> (ack_oe && !ack_on));

   // R9
   pulse_release_chk: assert property (@(posedge clk) disable iff (rst)
      (ack_oe && !ack_on && !straps.hold) |=> !ack_oe);

   // R8
   hold_no_neg_chk: assert property (@(posedge clk) disable iff (rst)
      (straps.hold && ack_oe) |-> ack_on);

   // R5
   par_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      par_err |=> par_err);

   // R1
   straps_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(straps));

endmodule

bind pbus_strap_slave pbus_strap_slave_chk chk_i (
   .clk(clk), .rst(rst), .straps(straps_q), .ack(ack),
   .ack_oe(ack_oe), .rd_oe(rd_oe), .par_err(par_err)
);

// File: tb/pbus_strap_slave_tb_top.sv
module pbus_strap_slave_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  gpio_in = 8'h00;
   logic [7:0]  gpio_rd, gpio_oe;
   logic        cs_n = 1'b1;
   logic        rw = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wpar = 1'b0;
   logic [31:0] rdata;
   logic        rpar, rd_oe, ack, ack_oe, par_err;

   int errors = 0;
   int checks = 0;

   logic [4:0]  cfg;          // current straps: {hold, even, ign, rw_inv, ack_high}
   logic [31:0] ref_mem [16];
   logic        ref_err;

   always #2 clk = ~clk;

   pbus_strap_slave dut_i (
      .clk(clk), .rst(rst), .gpio_in(gpio_in), .gpio_rd(gpio_rd), .gpio_oe(gpio_oe),
      .cs_n(cs_n), .rw(rw), .addr(addr), .wdata(wdata), .wpar(wpar),
      .rdata(rdata), .rpar(rpar), .rd_oe(rd_oe), .ack(ack), .ack_oe(ack_oe),
      .par_err(par_err)
   );

   function automatic logic exp_par(input logic [31:0] d, input logic even);
      int n = $countones(d);
      return even ? logic'(n % 2) : logic'((n + 1) % 2);
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic [4:0] s);
      @(negedge clk);
      cfg = s;
      gpio_in = {3'b000, s};
      rst = 1'b1;
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 16; i++) ref_mem[i] = '0;
      ref_err = 1'b0;
      @(negedge clk);
      check(ack_oe == 1'b0 && rd_oe == 1'b0, "R10 reset outputs idle",
            {30'b0, ack_oe, rd_oe}, 32'h0);
      check(par_err == 1'b0, "R5 reset par_err", {31'b0, par_err}, 32'h0);
      check(gpio_oe == 8'h00, "R1 gpio inputs", {24'b0, gpio_oe}, 32'h0);
      // change the pins after reset: straps must not follow
      gpio_in = {3'($urandom), ~s};
      @(negedge clk);
      check(gpio_rd == gpio_in, "R1 gpio_rd mirrors pins", {24'b0, gpio_rd},
            {24'b0, gpio_in});
   endtask

   task automatic xfer(input logic is_rd, input logic [3:0] a, input logic [31:0] d,
                       input logic bad);
      logic        ack_hi;
      logic [31:0] got_d;
      logic        got_p;
      int          lat;
      ack_hi = cfg[0];
      @(negedge clk);
      cs_n  = 1'b0;
      rw    = is_rd ^ cfg[1];
      addr  = a;
      wdata = d;
      wpar  = exp_par(d, cfg[3]) ^ bad;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!ack_oe && lat < 10);
      check(lat == 3, "R7 ack latency", lat, 3);
      check(ack == ack_hi, "R2 ack active level", {31'b0, ack}, {31'b0, ack_hi});
      check(rd_oe == is_rd, "R3/R10 read decode", {31'b0, rd_oe}, {31'b0, is_rd});
      got_d = rdata;
      got_p = rpar;
      if (is_rd) begin
         check(got_d == ref_mem[a], "R11 read data", got_d, ref_mem[a]);
         check(got_p == exp_par(got_d, cfg[3]), "R4 read parity", {31'b0, got_p},
               {31'b0, exp_par(got_d, cfg[3])});
      end else begin
         if (!bad || cfg[2]) ref_mem[a] = d;
         else                ref_err = 1'b1;
      end
      if (cfg[4]) begin
         repeat (2) begin
            @(negedge clk);
            check(ack_oe && ack == ack_hi && rd_oe == is_rd, "R8 ack held",
                  {29'b0, ack_oe, ack, rd_oe}, {29'b0, 1'b1, ack_hi, is_rd});
         end
         cs_n = 1'b1;
         repeat (2) begin
            @(negedge clk);
            check(ack_oe && ack == ack_hi, "R8 held until cs seen", {30'b0, ack_oe, ack},
                  {30'b0, 1'b1, ack_hi});
         end
         @(negedge clk);
         check(!ack_oe && !rd_oe, "R8 release", {30'b0, ack_oe, rd_oe}, 32'h0);
         repeat (2) @(negedge clk);
      end else begin
         @(negedge clk);
         check(ack_oe && ack == ~ack_hi && !rd_oe, "R9 driven inactive",
               {29'b0, ack_oe, ack, rd_oe}, {29'b0, 1'b1, ~ack_hi, 1'b0});
         check(ack == ~ack_hi, "R2 inactive level", {31'b0, ack}, {31'b0, ~ack_hi});
         repeat (2) begin
            @(negedge clk);
            check(!ack_oe && !rd_oe, "R9 tristate with cs held",
                  {30'b0, ack_oe, rd_oe}, 32'h0);
         end
         cs_n = 1'b1;
         repeat (4) @(negedge clk);
      end
      check(par_err == ref_err, is_rd ? "R5 flag after read" :
            (cfg[2] ? "R6 ignore parity" : "R5 parity check"),
            {31'b0, par_err}, {31'b0, ref_err});
   endtask

   initial begin
      void'($urandom(32'h5eed_0bad));
      for (int c = 0; c < 32; c++) begin
         do_reset(5'(c));
         // R11 registers reset to zero
         xfer(1'b1, 4'($urandom), '0, 1'b0);
         // R5/R6 directed bad-parity write followed by read-back
         xfer(1'b0, 4'd5, 32'hA5A5_0F0F ^ 32'(c), 1'b1);
         xfer(1'b1, 4'd5, '0, 1'b0);
         xfer(1'b0, 4'd15, 32'hFFFF_FFFF, 1'b0);
         xfer(1'b1, 4'd15, '0, 1'b0);
         xfer(1'b0, 4'd0, 32'h0000_0000, 1'b0);
         xfer(1'b1, 4'd0, '0, 1'b0);
         for (int k = 0; k < 10; k++) begin
            logic       rd_k  = 1'($urandom);
            logic       bad_k = ($urandom % 4) == 0;
            xfer(rd_k, 4'($urandom), $urandom, bad_k);
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule